// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block keeps the bookkeeping for three CAN transmit message buffers. Each buffer has a free/scheduled flag, an abort-request bit, an abort-acknowledge flag and an interrupt enable. A processor schedules a buffer by writing its flag register and requests aborts through its control register. A transmit engine reports, per buffer, when a frame goes on the bus, completes, loses arbitration or hits an error. In return the block gives the engine a mask of scheduled buffers, and it raises an interrupt when a buffer is free and enabled.

An abort is honoured only while the frame is not on the bus. Once the engine has started a buffer, a pending request waits for the result. A failed attempt (lost arbitration or bus error) turns into a granted abort. A completed frame simply frees the buffer and drops the request. A soft-reset input holds all buffer flags in their reset state for as long as it is asserted. The interrupt enables are kept.

Engine inputs and register writes are sampled on the rising clock edge, and their effect shows at the outputs after that edge. Register reads are combinational.

Top module: `can_tx_abort`

## Requirements
- R1: After reset, all free flags read 1, all acknowledge and request bits read 0, all interrupt enables are 0 and irq is 0. The flag register (address 0) reads 0x07 and the control register (address 1) reads 0x00.
- R2: In the flag register, bit i (0 to 2) is the free flag of buffer i and bit 4+i is its acknowledge flag. Writing 1 to bit i of a free buffer schedules it: its free flag drops, schedMask bit i rises and its acknowledge flag clears. Writing 1 to bit i of a buffer that is already scheduled, writing 0, and writing the acknowledge bits all have no effect.
- R3: In the control register, bits 4 to 6 are the abort requests for buffers 0 to 2. Writing 1 sets the request of a scheduled buffer. For a free buffer the write is ignored, and the bit reads 0.
- R4: A request on a scheduled buffer that the engine has not started is granted at the next clock edge. The buffer's free flag and acknowledge flag are set, and its request clears.
- R5: Once the engine has reported a start, a pending request is held and the buffer stays scheduled. A lost-arbitration or bus-error report then grants the abort: the free flag sets, the acknowledge flag sets and the request clears.
- R6: A successful-completion report frees the buffer, leaves its acknowledge flag at 0 and drops any pending request.
- R7: A failure report without a pending request leaves the buffer scheduled. The attempt no longer counts as started, so a later request is granted at the next edge.
- R8: A request bit is never 1 while its buffer's free flag is 1.
- R9: While softReset is 1, every free flag is held at 1 and every acknowledge and request bit at 0, whatever the register writes or engine reports. The interrupt enables keep their values.
- R10: irq is the OR, over all buffers, of the free flag ANDed with that buffer's interrupt enable.
- R11: In the control register, bits 0 to 2 are the interrupt enables, written directly. Bits 3 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Holds the buffer flags in their reset state while 1 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 flag register, 1 control register |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data of the selected register |
| txStart | input | 3 | Engine has put the buffer's frame on the bus |
| txDone | input | 3 | Frame sent successfully |
| txArbLost | input | 3 | Frame lost arbitration |
| txError | input | 3 | Frame ended in a bus error |
| schedMask | output | 3 | Buffers scheduled for transmission |
| emptyFlags | output | 3 | Free flag per buffer |
| abortAck | output | 3 | Abort acknowledge per buffer |
| abortReq | output | 3 | Pending abort request per buffer |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the split between requests that arrive before the engine starts and requests that arrive after it. If the start tracking were missing, a request on a buffer already on the bus would be granted at once instead of being held. It also checks that a completed frame never sets an acknowledge flag, that a failure without a request keeps the buffer scheduled, and that requests and schedule writes on free buffers are ignored. A design that got these wrong would report aborts that never happened or lose frames. It also sweeps every combination of free flags against interrupt enables, and checks that soft reset overrides simultaneous writes and reports while keeping the enables.

// File: rtl/can_tx_abort_pkg.sv
`timescale 1ns/1ps
package can_tx_abort_pkg;

  typedef enum logic {
    REG_FLAG = 1'b0,
    REG_CTRL = 1'b1
  } regSel_e;

  // per-buffer strobes from control to datapath
  typedef struct packed {
    logic setEmpty;
    logic clrEmpty;
    logic setAck;
    logic clrAck;
    logic setReq;
    logic clrReq;
    logic setFlight;
    logic clrFlight;
  } bufStrobe_t;

  // register-level strobes
  typedef struct packed {
    logic ieLoad;
  } regStrobe_t;

endpackage

// File: rtl/can_tx_abort_ctrl.sv
`timescale 1ns/1ps
module can_tx_abort_ctrl
  import can_tx_abort_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int DATA_W  = 8
) (
  input  logic                          softReset,
  input  logic                          regWrEn,
  input  logic                          regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  input  logic [NUM_BUF-1:0]            txStart,
  input  logic [NUM_BUF-1:0]            txDone,
  input  logic [NUM_BUF-1:0]            txArbLost,
  input  logic [NUM_BUF-1:0]            txError,
  input  logic [NUM_BUF-1:0]            emptyQ,
  input  logic [NUM_BUF-1:0]            reqQ,
  input  logic [NUM_BUF-1:0]            flightQ,
  output bufStrobe_t [NUM_BUF-1:0]      bufStb,
  output regStrobe_t                    regStb
);

  // upper half of a register holds the second per-buffer field
  localparam int HI_LSB = DATA_W / 2;

  logic flagWr;
  logic ctrlWr;
  logic [NUM_BUF-1:0] sched;
  logic [NUM_BUF-1:0] fail;
  logic [NUM_BUF-1:0] grant;
  logic [NUM_BUF-1:0] schedWr;
  logic [NUM_BUF-1:0] reqWr;

  assign flagWr  = regWrEn && (regSel_e'(regAddr) == REG_FLAG);
  assign ctrlWr  = regWrEn && (regSel_e'(regAddr) == REG_CTRL);
  assign sched   = ~emptyQ;
  assign fail    = txArbLost | txError;
  // abort is honoured before the bus is taken, or after a failed attempt
  assign grant   = sched & reqQ & (~flightQ | fail);
  assign schedWr = {NUM_BUF{flagWr}} & regWrData[NUM_BUF-1:0] & emptyQ;
  assign reqWr   = {NUM_BUF{ctrlWr}} & regWrData[HI_LSB +: NUM_BUF] & sched;

  assign regStb.ieLoad = ctrlWr;

  always_comb begin
    bufStb = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (softReset) begin
        bufStb[i].setEmpty  = 1'b1;
        bufStb[i].clrAck    = 1'b1;
        bufStb[i].clrReq    = 1'b1;
        bufStb[i].clrFlight = 1'b1;
      end else if (sched[i] && txDone[i]) begin
        bufStb[i].setEmpty  = 1'b1;
        bufStb[i].clrAck    = 1'b1;
        bufStb[i].clrReq    = 1'b1;
        bufStb[i].clrFlight = 1'b1;
      end else if (grant[i]) begin
        bufStb[i].setEmpty  = 1'b1;
        bufStb[i].setAck    = 1'b1;
        bufStb[i].clrReq    = 1'b1;
        bufStb[i].clrFlight = 1'b1;
      end else if (sched[i]) begin
        if (fail[i]) begin
          bufStb[i].clrFlight = 1'b1;
        end else if (txStart[i]) begin
          bufStb[i].setFlight = 1'b1;
        end
        bufStb[i].setReq = reqWr[i];
      end else if (schedWr[i]) begin
        bufStb[i].clrEmpty  = 1'b1;
        bufStb[i].clrAck    = 1'b1;
        bufStb[i].clrFlight = 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_tx_abort_dp.sv
`timescale 1ns/1ps
module can_tx_abort_dp
  import can_tx_abort_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int DATA_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bufStrobe_t [NUM_BUF-1:0] bufStb,
  input  regStrobe_t               regStb,
  input  logic                     regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        regRdData,
  output logic [NUM_BUF-1:0]       emptyQ,
  output logic [NUM_BUF-1:0]       ackQ,
  output logic [NUM_BUF-1:0]       reqQ,
  output logic [NUM_BUF-1:0]       flightQ,
  output logic                     irq
);

  localparam int HI_LSB = DATA_W / 2;

  logic [NUM_BUF-1:0] ieQ;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slice
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        emptyQ[i]  <= 1'b1;
        ackQ[i]    <= 1'b0;
        reqQ[i]    <= 1'b0;
        flightQ[i] <= 1'b0;
      end else begin
        if (bufStb[i].setEmpty)       emptyQ[i] <= 1'b1;
        else if (bufStb[i].clrEmpty)  emptyQ[i] <= 1'b0;
        if (bufStb[i].setAck)         ackQ[i] <= 1'b1;
        else if (bufStb[i].clrAck)    ackQ[i] <= 1'b0;
        if (bufStb[i].clrReq)         reqQ[i] <= 1'b0;
        else if (bufStb[i].setReq)    reqQ[i] <= 1'b1;
        if (bufStb[i].clrFlight)      flightQ[i] <= 1'b0;
        else if (bufStb[i].setFlight) flightQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ <= '0;
    end else if (regStb.ieLoad) begin
      ieQ <= regWrData[NUM_BUF-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel_e'(regAddr) == REG_FLAG) begin
      regRdData[NUM_BUF-1:0]        = emptyQ;
      regRdData[HI_LSB +: NUM_BUF]  = ackQ;
    end else begin
      regRdData[NUM_BUF-1:0]        = ieQ;
      regRdData[HI_LSB +: NUM_BUF]  = reqQ;
    end
  end

  assign irq = |(emptyQ & ieQ);

endmodule

// File: rtl/can_tx_abort.sv
`timescale 1ns/1ps
module can_tx_abort
  import can_tx_abort_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softReset,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_BUF-1:0] txStart,
  input  logic [NUM_BUF-1:0] txDone,
  input  logic [NUM_BUF-1:0] txArbLost,
  input  logic [NUM_BUF-1:0] txError,
  output logic [NUM_BUF-1:0] schedMask,
  output logic [NUM_BUF-1:0] emptyFlags,
  output logic [NUM_BUF-1:0] abortAck,
  output logic [NUM_BUF-1:0] abortReq,
  output logic               irq
);

  bufStrobe_t [NUM_BUF-1:0] bufStb;
  regStrobe_t               regStb;
  logic [NUM_BUF-1:0]       flightQ;

  can_tx_abort_ctrl #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_ctrl (
    .softReset (softReset),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .txStart   (txStart),
    .txDone    (txDone),
    .txArbLost (txArbLost),
    .txError   (txError),
    .emptyQ    (emptyFlags),
    .reqQ      (abortReq),
    .flightQ   (flightQ),
    .bufStb    (bufStb),
    .regStb    (regStb)
  );

  can_tx_abort_dp #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bufStb    (bufStb),
    .regStb    (regStb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .emptyQ    (emptyFlags),
    .ackQ      (abortAck),
    .reqQ      (abortReq),
    .flightQ   (flightQ),
    .irq       (irq)
  );

  assign schedMask = ~emptyFlags;

endmodule

// File: rtl/can_tx_abort_chk.sv
`timescale 1ns/1ps
module can_tx_abort_chk #(
  parameter int NUM_BUF = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               softReset,
  input logic [NUM_BUF-1:0] txDone,
  input logic [NUM_BUF-1:0] txArbLost,
  input logic [NUM_BUF-1:0] txError,
  input logic [NUM_BUF-1:0] emptyFlags,
  input logic [NUM_BUF-1:0] abortAck,
  input logic [NUM_BUF-1:0] abortReq,
  input logic               irq
);

  // R8
  req_vs_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq & emptyFlags) == '0);

  // R4
  ack_needs_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortAck & ~emptyFlags) == '0);

  // R9
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> ((&emptyFlags) && (abortAck == '0) && (abortReq == '0)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (emptyFlags != '0));

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    // R6
    done_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
      (txDone[i] && !emptyFlags[i] && !softReset)
        |=> (emptyFlags[i] && !abortAck[i] && !abortReq[i]));

    // R5
    fail_grants_chk: assert property (@(posedge clk) disable iff (!rstN)
      (abortReq[i] && !emptyFlags[i] && (txArbLost[i] || txError[i])
        && !txDone[i] && !softReset)
        |=> (emptyFlags[i] && abortAck[i]));

    // R2
    sched_clears_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(emptyFlags[i]) |-> !abortAck[i]);
  end

endmodule

bind can_tx_abort can_tx_abort_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .softReset  (softReset),
  .txDone     (txDone),
  .txArbLost  (txArbLost),
  .txError    (txError),
  .emptyFlags (emptyFlags),
  .abortAck   (abortAck),
  .abortReq   (abortReq),
  .irq        (irq)
);

// File: tb/test_can_tx_abort.sv
`timescale 1ns/1ps
module test_can_tx_abort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softReset = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [2:0] txStart = '0, txDone = '0, txArbLost = '0, txError = '0;
  logic [2:0] schedMask, emptyFlags, abortAck, abortReq;
  logic       irq;

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;
  bit finished = 0;

  can_tx_abort i_can_tx_abort (
    .clk(clk), .rstN(rstN), .softReset(softReset),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .txStart(txStart), .txDone(txDone), .txArbLost(txArbLost),
    .txError(txError),
    .schedMask(schedMask), .emptyFlags(emptyFlags), .abortAck(abortAck),
    .abortReq(abortReq), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      report();
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic engine(input logic [2:0] st, input logic [2:0] dn,
                        input logic [2:0] al, input logic [2:0] er);
    txStart = st; txDone = dn; txArbLost = al; txError = er;
    tick();
    txStart = '0; txDone = '0; txArbLost = '0; txError = '0;
  endtask

  task automatic softPulse();
    softReset = 1'b1;
    tick();
    softReset = 1'b0;
  endtask

  logic [7:0] rv;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;

    // R1 reset state
    check("R1 free", {5'd0, emptyFlags}, 8'h07);
    check("R1 ack", {5'd0, abortAck}, 8'h00);
    check("R1 req", {5'd0, abortReq}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rdReg(1'b0, rv); check("R1 flagreg", rv, 8'h07);
    rdReg(1'b1, rv); check("R1 ctrlreg", rv, 8'h00);

    // R2 schedule writes, all masks, ack bits written as junk
    for (int m = 0; m < 8; m++) begin
      softPulse();
      wrReg(1'b0, 8'hF0 | 8'(m));
      check("R2 free", {5'd0, emptyFlags}, 8'(~m & 7));
      check("R2 mask", {5'd0, schedMask}, 8'(m));
      check("R2 ack", {5'd0, abortAck}, 8'h00);
      wrReg(1'b0, 8'(m));
      wrReg(1'b0, 8'h00);
      rdReg(1'b0, rv); check("R2 no effect", rv, 8'(~m & 7));
    end

    // R10 / R11 sweep: free pattern x enables
    for (int e = 0; e < 8; e++) begin
      for (int ie = 0; ie < 8; ie++) begin
        softPulse();
        wrReg(1'b0, 8'(~e & 7));
        wrReg(1'b1, 8'h88 | 8'(ie));
        check("R10 irq", {7'd0, irq}, {7'd0, ((e & ie) != 0)});
        rdReg(1'b1, rv); check("R11 ctrl readback", rv, 8'(ie));
      end
    end
    wrReg(1'b1, 8'h00);

    // R3 / R4 request before start, all masks
    for (int m = 0; m < 8; m++) begin
      softPulse();
      wrReg(1'b0, 8'(m));
      wrReg(1'b1, 8'h70);
      check("R3 req set only on scheduled", {5'd0, abortReq}, 8'(m));
      rdReg(1'b1, rv); check("R3 ctrl read", rv, 8'(m << 4));
      tick();
      check("R4 free", {5'd0, emptyFlags}, 8'h07);
      check("R4 ack", {5'd0, abortAck}, 8'(m));
      check("R4 req", {5'd0, abortReq}, 8'h00);
      rdReg(1'b0, rv); check("R4 flagreg", rv, 8'(m << 4) | 8'h07);
      wrReg(1'b0, 8'(m));
      check("R2 sched clears ack", {5'd0, abortAck}, 8'h00);
    end

    // R5 request after start, failure grants
    for (int i = 0; i < 3; i++) begin
      for (int f = 0; f < 2; f++) begin
        softPulse();
        wrReg(1'b0, 8'(1 << i));
        engine(3'(1 << i), 3'd0, 3'd0, 3'd0);
        wrReg(1'b1, 8'(8'h10 << i));
        repeat (3) tick();
        check("R5 held req", {5'd0, abortReq}, 8'(1 << i));
        check("R5 held sched", {5'd0, schedMask}, 8'(1 << i));
        engine(3'd0, 3'd0, f ? 3'd0 : 3'(1 << i), f ? 3'(1 << i) : 3'd0);
        check("R5 free", {5'd0, emptyFlags}, 8'h07);
        check("R5 ack", {5'd0, abortAck}, 8'(1 << i));
        check("R5 req", {5'd0, abortReq}, 8'h00);
      end
    end

    // R6 completion, with and without a request
    for (int i = 0; i < 3; i++) begin
      for (int r = 0; r < 2; r++) begin
        softPulse();
        wrReg(1'b0, 8'(1 << i));
        engine(3'(1 << i), 3'd0, 3'd0, 3'd0);
        if (r == 1) wrReg(1'b1, 8'(8'h10 << i));
        engine(3'd0, 3'(1 << i), 3'd0, 3'd0);
        check("R6 free", {5'd0, emptyFlags}, 8'h07);
        check("R6 ack", {5'd0, abortAck}, 8'h00);
        check("R6 req", {5'd0, abortReq}, 8'h00);
      end
    end

    // R7 failure without request, then late request
    for (int i = 0; i < 3; i++) begin
      softPulse();
      wrReg(1'b0, 8'(1 << i));
      engine(3'(1 << i), 3'd0, 3'd0, 3'd0);
      engine(3'd0, 3'd0, 3'(1 << i), 3'd0);
      check("R7 still scheduled", {5'd0, schedMask}, 8'(1 << i));
      check("R7 ack", {5'd0, abortAck}, 8'h00);
      wrReg(1'b1, 8'(8'h10 << i));
      check("R7 req visible", {5'd0, abortReq}, 8'(1 << i));
      tick();
      check("R7 granted", {5'd0, abortAck}, 8'(1 << i));
      check("R7 free", {5'd0, emptyFlags}, 8'h07);
    end

    // R9 soft reset overrides writes and reports, keeps enables
    softPulse();
    wrReg(1'b1, 8'h05);
    wrReg(1'b0, 8'h07);
    engine(3'b111, 3'd0, 3'd0, 3'd0);
    wrReg(1'b1, 8'h75);
    check("R9 setup req", {5'd0, abortReq}, 8'h07);
    softReset = 1'b1;
    wrReg(1'b0, 8'h07);
    check("R9 free held", {5'd0, emptyFlags}, 8'h07);
    check("R9 req cleared", {5'd0, abortReq}, 8'h00);
    engine(3'd0, 3'b111, 3'b111, 3'd0);
    check("R9 ack held", {5'd0, abortAck}, 8'h00);
    softReset = 1'b0;
    rdReg(1'b1, rv); check("R9 enables kept", rv, 8'h05);
    check("R10 irq after soft reset", {7'd0, irq}, 8'h01);

    report();
  end

endmodule